// File: doc/BRIEF.md
# Timestamped Event Queue Controller

This block sits in front of a peripheral and hands it commands at set times. A loader writes events into a small memory-mapped register window. Each event is 128 bits: a 64-bit release time and a 64-bit payload. Each finished event goes into a first-in first-out queue instead of running on arrival. A free-running 64-bit time counter starts at zero when reset is released. When the counter has reached the release time of the event at the head of the queue, the block pops that event. It then raises a one-cycle execute strobe with the payload for the wrapped function.

Two watermark interrupts let a loader pace itself. One is raised when the queue is nearly full, so the loader stops writing. The other is raised when the queue is nearly empty, so the loader can refill it. Both thresholds can be programmed. Two sticky error flags report an event that was popped after its time had passed, and a write that was dropped because the queue was full. All four flags are cleared by writing ones to a clear register.

Top module: `evq_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle it is released, `exec_o`, all four flags and `time_o` read zero, and the queue is empty.
- R2: An event is assembled from word writes: address 0 is release time bits 31:0, address 1 is time bits 63:32, address 2 is payload bits 31:0, and address 3 is payload bits 63:32. The write to address 3 pushes the assembled event.
- R3: `time_o` increments by one every cycle after reset. When the head event's time is less than or equal to the counter value in a cycle, `exec_o` is high in the next cycle and `exec_payload_o` carries that event's payload.
- R4: Events execute in the order they were written. A head event whose time has not arrived holds back every later event, even one with an earlier time. At most one event is released per cycle.
- R5: An event popped while its time is strictly below the counter sets `err_late_o` in the next cycle. It still executes.
- R6: The queue holds DEPTH events (2048 by default). A push while the queue is full is dropped and sets `err_ovf_o` in the next cycle.
- R7: `irq_afull_o` becomes set in the cycle after the queue count is greater than or equal to the near-full threshold, which is written at address 4 (reset value DEPTH-DEPTH/8). Once set, it stays set until cleared by writing 1 to bit 0 of address 6. If the condition still holds, setting wins over clearing.
- R8: `irq_aempty_o` becomes set in the cycle after the count is less than or equal to the near-empty threshold, which is written at address 5 (reset value DEPTH/8). Once set, it stays set until cleared by writing 1 to bit 1 of address 6. If the condition still holds, setting wins over clearing.
- R9: `err_late_o` is cleared by bit 2 of address 6 and `err_ovf_o` by bit 3. Both stay set otherwise, and a new error in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| time_o | output | 64 | Global time counter |
| exec_o | output | 1 | One-cycle execute strobe |
| exec_payload_o | output | 64 | Payload of the released event |
| irq_afull_o | output | 1 | Near-full interrupt, held until cleared |
| irq_aempty_o | output | 1 | Near-empty interrupt, held until cleared |
| err_late_o | output | 1 | Sticky late-event flag |
| err_ovf_o | output | 1 | Sticky dropped-write flag |

## Verification
A pushed event reaches the head at the edge that carries the write to address 3. From then on it is compared against the counter in every cycle. The execute strobe and payload appear one cycle after the first cycle in which the counter has reached the event's time. The four flags respond one cycle after their condition, and a clear takes effect at the edge that carries the write. The bench reference model advances at each rising edge from the values present before that edge and compares every output at the falling edge, so each result is sampled in exactly the cycle it is due.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int TS_W = 64;
  localparam int PL_W = 64;
  localparam int FLAG_N = 4;

  typedef struct packed {
    logic [TS_W-1:0] ts;
    logic [PL_W-1:0] pl;
  } evt_t;

  typedef enum logic [2:0] {
    REG_TS_LO  = 3'd0,
    REG_TS_HI  = 3'd1,
    REG_PL_LO  = 3'd2,
    REG_PL_HI  = 3'd3,
    REG_AFULL  = 3'd4,
    REG_AEMPTY = 3'd5,
    REG_CLR    = 3'd6
  } reg_addr_e;

  // flag bit order, shared by clear register and flag block
  localparam int F_AFULL  = 0;
  localparam int F_AEMPTY = 1;
  localparam int F_LATE   = 2;
  localparam int F_OVF    = 3;
endpackage

// File: rtl/evq_regs.sv
module evq_regs
  import evq_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int AFULL_INIT  = 1792,
  parameter int AEMPTY_INIT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              push_o,
  output evt_t              evt_o,
  output logic [CNT_W-1:0]  afull_thr_o,
  output logic [CNT_W-1:0]  aempty_thr_o,
  output logic [FLAG_N-1:0] clr_o
);
  localparam int STAGE_N = 3;

  logic [31:0] stage_w [STAGE_N];

  for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    word_q <= '0;
      else if (wr_valid_i && wr_addr_i == 3'(g))      word_q <= wr_data_i;
    end
    assign stage_w[g] = word_q;
  end

  logic [CNT_W-1:0] afull_thr_q, aempty_thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      afull_thr_q  <= CNT_W'(AFULL_INIT);
      aempty_thr_q <= CNT_W'(AEMPTY_INIT);
    end else if (wr_valid_i) begin
      if (wr_addr_i == REG_AFULL)  afull_thr_q  <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == REG_AEMPTY) aempty_thr_q <= wr_data_i[CNT_W-1:0];
    end
  end

  // last payload word completes the event and pushes it
  assign push_o       = wr_valid_i && (wr_addr_i == REG_PL_HI);
  assign evt_o.ts     = {stage_w[REG_TS_HI], stage_w[REG_TS_LO]};
  assign evt_o.pl     = {wr_data_i, stage_w[REG_PL_LO]};
  assign afull_thr_o  = afull_thr_q;
  assign aempty_thr_o = aempty_thr_q;
  assign clr_o        = (wr_valid_i && wr_addr_i == REG_CLR) ? wr_data_i[FLAG_N-1:0] : '0;
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
  import evq_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  evt_t             evt_i,
  input  logic             pop_i,
  output evt_t             head_o,
  output logic             empty_o,
  output logic             drop_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  evt_t             mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full, wr_en, rd_en;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign wr_en   = push_i && !full;
  assign rd_en   = pop_i && !empty_o;
  assign drop_o  = push_i && full;
  assign head_o  = mem[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_ptr_q] <= evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_en) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (count_q == $past(count_q)));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/evq_sched.sv
module evq_sched
  import evq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  evt_t            head_i,
  input  logic            empty_i,
  output logic            pop_o,
  output logic            late_o,
  output logic [TS_W-1:0] time_o,
  output logic            exec_o,
  output logic [PL_W-1:0] exec_pl_o
);
  logic [TS_W-1:0] time_q;
  logic            exec_q;
  logic [PL_W-1:0] pl_q;

  assign pop_o  = !empty_i && (head_i.ts <= time_q);
  assign late_o = pop_o && (head_i.ts < time_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      exec_q <= 1'b0;
      pl_q   <= '0;
    end else begin
      time_q <= time_q + 1'b1;
      exec_q <= pop_o;
      if (pop_o) pl_q <= head_i.pl;
    end
  end

  assign time_o    = time_q;
  assign exec_o    = exec_q;
  assign exec_pl_o = pl_q;

  assert_exec_due_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> ($past(head_i.ts) <= $past(time_q)));

  assert_exec_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> !$past(empty_i));
endmodule

// File: rtl/evq_flags.sv
module evq_flags
  import evq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  afull_thr_i,
  input  logic [CNT_W-1:0]  aempty_thr_i,
  input  logic              late_i,
  input  logic              drop_i,
  input  logic [FLAG_N-1:0] clr_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic [FLAG_N-1:0] set_v;

  always_comb begin
    set_v           = '0;
    set_v[F_AFULL]  = (count_i >= afull_thr_i);
    set_v[F_AEMPTY] = (count_i <= aempty_thr_i);
    set_v[F_LATE]   = late_i;
    set_v[F_OVF]    = drop_i;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    logic bit_q;
    // set beats clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= (bit_q && !clr_i[g]) || set_v[g];
    end
    assign flags_o[g] = bit_q;
  end

  assert_afull_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i >= afull_thr_i) |=> flags_o[F_AFULL]);

  assert_aempty_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i <= aempty_thr_i) |=> flags_o[F_AEMPTY]);

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[F_OVF] && !clr_i[F_OVF]) |=> flags_o[F_OVF]);

  assert_late_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[F_LATE] && !clr_i[F_LATE]) |=> flags_o[F_LATE]);
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int DEPTH       = 2048,
  parameter int AFULL_INIT  = DEPTH - DEPTH/8,
  parameter int AEMPTY_INIT = DEPTH/8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [63:0] time_o,
  output logic        exec_o,
  output logic [63:0] exec_payload_o,
  output logic        irq_afull_o,
  output logic        irq_aempty_o,
  output logic        err_late_o,
  output logic        err_ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push, pop, empty, drop, late;
  evt_t              wr_evt, head;
  logic [CNT_W-1:0]  count, afull_thr, aempty_thr;
  logic [FLAG_N-1:0] clr, flags;

  evq_regs #(.CNT_W(CNT_W), .AFULL_INIT(AFULL_INIT), .AEMPTY_INIT(AEMPTY_INIT)) u_regs (
    .clk_i, .rst_ni,
    .wr_valid_i(reg_wr_i), .wr_addr_i(reg_addr_i), .wr_data_i(reg_wdata_i),
    .push_o(push), .evt_o(wr_evt),
    .afull_thr_o(afull_thr), .aempty_thr_o(aempty_thr), .clr_o(clr)
  );

  evq_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .evt_i(wr_evt), .pop_i(pop),
    .head_o(head), .empty_o(empty), .drop_o(drop), .count_o(count)
  );

  evq_sched u_sched (
    .clk_i, .rst_ni,
    .head_i(head), .empty_i(empty),
    .pop_o(pop), .late_o(late), .time_o(time_o),
    .exec_o(exec_o), .exec_pl_o(exec_payload_o)
  );

  evq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i, .rst_ni,
    .count_i(count), .afull_thr_i(afull_thr), .aempty_thr_i(aempty_thr),
    .late_i(late), .drop_i(drop), .clr_i(clr), .flags_o(flags)
  );

  assign irq_afull_o  = flags[F_AFULL];
  assign irq_aempty_o = flags[F_AEMPTY];
  assign err_late_o   = flags[F_LATE];
  assign err_ovf_o    = flags[F_OVF];
endmodule

// File: tb/evq_ctrl_tb.sv
module evq_ctrl_tb;
  localparam int DEPTH  = 8;
  localparam int WD_MAX = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [63:0] time_o, exec_payload_o;
  logic        exec_o, irq_afull_o, irq_aempty_o, err_late_o, err_ovf_o;

  always #2.5 clk = ~clk;

  evq_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .time_o, .exec_o, .exec_payload_o,
    .irq_afull_o, .irq_aempty_o, .err_late_o, .err_ovf_o
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // reference model
  logic [127:0] mq[$];
  logic [63:0]  mt, m_pl;
  logic [31:0]  st_tsl, st_tsh, st_pll;
  int           m_afthr, m_aethr, cnt;
  logic         m_exec, m_af, m_ae, m_late, m_ovf;
  logic         pop_d, late_d, push_d, drop_d;
  logic [3:0]   clr_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      mt = 0; m_pl = 0; m_exec = 0;
      st_tsl = 0; st_tsh = 0; st_pll = 0;
      m_afthr = DEPTH - DEPTH/8; m_aethr = DEPTH/8;
      m_af = 0; m_ae = 0; m_late = 0; m_ovf = 0;
    end else begin
      cnt    = mq.size();
      pop_d  = (cnt > 0) && (mq[0][127:64] <= mt);
      late_d = pop_d && (mq[0][127:64] < mt);
      if (pop_d) m_pl = mq[0][63:0];
      push_d = reg_wr && reg_addr == 3'd3;
      drop_d = push_d && cnt == DEPTH;
      clr_d  = (reg_wr && reg_addr == 3'd6) ? reg_wdata[3:0] : 4'h0;
      m_af   = (m_af   && !clr_d[0]) || (cnt >= m_afthr);
      m_ae   = (m_ae   && !clr_d[1]) || (cnt <= m_aethr);
      m_late = (m_late && !clr_d[2]) || late_d;
      m_ovf  = (m_ovf  && !clr_d[3]) || drop_d;
      if (pop_d) void'(mq.pop_front());
      if (push_d && !drop_d) mq.push_back({st_tsh, st_tsl, reg_wdata, st_pll});
      if (reg_wr) begin
        case (reg_addr)
          3'd0: st_tsl = reg_wdata;
          3'd1: st_tsh = reg_wdata;
          3'd2: st_pll = reg_wdata;
          3'd4: m_afthr = int'(reg_wdata[3:0]);
          3'd5: m_aethr = int'(reg_wdata[3:0]);
          default: ;
        endcase
      end
      m_exec = pop_d;
      mt = mt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 time", time_o, mt);
      chk("R3 exec strobe", {63'd0, exec_o}, {63'd0, m_exec});
      if (m_exec) chk("R2,R4 payload", exec_payload_o, m_pl);
      chk("R7 afull", {63'd0, irq_afull_o}, {63'd0, m_af});
      chk("R8 aempty", {63'd0, irq_aempty_o}, {63'd0, m_ae});
      chk("R5,R9 late", {63'd0, err_late_o}, {63'd0, m_late});
      chk("R6,R9 ovf", {63'd0, err_ovf_o}, {63'd0, m_ovf});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
    end
  endtask

  task automatic push_evt(input logic [63:0] ts, input logic [63:0] pl);
    wr(3'd0, ts[31:0]);
    wr(3'd1, ts[63:32]);
    wr(3'd2, pl[31:0]);
    wr(3'd3, pl[63:32]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 exec", {63'd0, exec_o}, 64'd0);
    chk("R1 time", time_o, 64'd0);
    chk("R1 flags", {60'd0, irq_afull_o, irq_aempty_o, err_late_o, err_ovf_o}, 64'd0);
    rst_n = 1'b1;
    idle(2);
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd1);
    idle(1);
    begin
      logic [63:0] t = time_o;
      push_evt(t + 30, 64'hA1A1_0000_0000_00A1);
      push_evt(t + 32, 64'hB2B2_0000_0000_00B2);
    end
    idle(40);
    begin
      logic [63:0] t = time_o;
      push_evt(t + 60, 64'hC3C3_C3C3_0000_0003);
      push_evt(t + 20, 64'hD4D4_D4D4_0000_0004); // R4: blocked behind C, then late (R5)
      push_evt(t + 80, 64'hE5E5_E5E5_0000_0005);
    end
    idle(100);
    wr(3'd6, 32'h4); // R9 clear late
    idle(3);
    push_evt(64'd3, 64'hF6F6_0000_0000_0006); // R5 stale event
    idle(5);
    wr(3'd6, 32'h4);
    idle(3);
    begin
      logic [63:0] t = time_o;
      push_evt(t + 30, 64'h1111_0000_0000_0007);
      push_evt(t + 30, 64'h2222_0000_0000_0008); // R4 back-to-back release
    end
    idle(40);
    begin
      logic [63:0] t = time_o;
      for (int i = 0; i < DEPTH + 2; i++)
        push_evt(t + 200 + 64'(i), 64'h5A00_0000_0000_0000 | 64'(i)); // R6 fill past DEPTH
    end
    idle(2);
    wr(3'd6, 32'h1); // R7 clear while still full: set wins
    wr(3'd6, 32'h8); // R9 clear ovf
    idle(250);
    wr(3'd6, 32'hF);
    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < WD_MAX; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R3 watchdog got=%0d exp<%0d", WD_MAX, WD_MAX);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule